// File: doc/BRIEF.md
# Supercolumn Double-Data-Rate Row Serializer

This block is the periphery readout engine of a pixel matrix with 256 columns. The pixel array supplies one row of 4-bit counter slices in parallel. The block reads each row and splits it into supercolumns of eight adjacent columns. Each supercolumn is shifted out on its own data line. All lines run together, and each line carries two bits per clock of the fast readout clock. The pad-level double-data-rate cell is modelled as a rising-edge bit and a falling-edge bit per cycle.

A sequencer walks through every row of the frame. For each row it requests one, two or three 4-bit slices, depending on the counter depth chosen for the frame. The block reports the current row and slice on its address outputs. The array answers combinationally on the row input.

Several blocks share the readout by passing a token. A block starts its frame when a token pulse arrives, and it hands the token on when its frame is done. For testing, a slow mode sends the whole row on one line, one bit per clock.

Top module: `scser_top`

## Requirements
- R1: After synchronous reset, every data output, `frame_done` and `token_out` is 0, and the block waits idle for a token.
- R2: While no frame is in progress, all data outputs stay 0. A `token_in` pulse that arrives during a frame is ignored and does not restart the sequence.
- R3: After a token is accepted, rows 0 to NUM_ROWS-1 are visited in ascending order. Within each row, `nib_sel` counts up from 0. The slice count per row is set by `count_depth`: code 0 gives 1 slice, code 1 gives 2 slices, and codes 2 and 3 give 3 slices. `row_addr` and `nib_sel` show the slice being loaded in the load cycle that precedes its first output bit.
- R4: Column c occupies bits [4c+3:4c] of `row_data`. Supercolumn s carries columns 8s to 8s+7. Within a supercolumn, bit index i = (c-8s)*4 + b, so the lowest column comes first and the least significant bit comes first. In output cycle k of a word, `dout_rise[s]` carries bit 2k and `dout_fall[s]` carries bit 2k+1.
- R5: In fast mode, one word takes 16 output cycles. Exactly one load cycle, with all outputs 0, separates consecutive words, so a new row load happens only after the previous word has been fully shifted.
- R6: `frame_done` and `token_out` are high together for exactly one cycle, in the cycle after the last output bit of the frame. The block is then idle.
- R7: In slow mode (`slow_mode`=1), `dout_slow` carries row bit j in output cycle j, for j from 0 to 1023. Supercolumn words therefore follow each other on one line. `dout_rise` and `dout_fall` stay 0 in slow mode, and `dout_slow` stays 0 in fast mode.
- R8: `slow_mode` and `count_depth` are sampled when the token is accepted. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock |
| rst | input | 1 | Synchronous active-high reset |
| token_in | input | 1 | Token pulse that starts a frame |
| slow_mode | input | 1 | 1 = single-line slow test readout |
| count_depth | input | 2 | Counter depth code (slices per row) |
| row_data | input | NUM_COLS*4 | Requested row slice from the pixel array |
| row_addr | output | ROW_W | Row being requested |
| nib_sel | output | 2 | Slice of the row being requested |
| dout_rise | output | NUM_COLS/8 | Rising-edge bit per supercolumn line |
| dout_fall | output | NUM_COLS/8 | Falling-edge bit per supercolumn line |
| dout_slow | output | 1 | Slow serial test line |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| token_out | output | 1 | One-cycle token handed to the next block |

## Verification
The bench drives frames with three pixel patterns:
- A per-column hash that differs for every row and slice. It exposes swapped columns, reversed bit order, and a wrong row or slice.
- A single walking column. It shows which supercolumn line and which edge each column lands on.
- An alternating 0xA/0x5 pattern. It separates rising-edge bits from falling-edge bits.

Every depth code is run in fast mode, and two depths are run in slow mode. One frame toggles the mode inputs and pulses the token part-way through. This shows that both the sampled configuration and the ignored token leave the frame unchanged.

// File: rtl/scser_pkg.sv
package scser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       slow;
        logic [1:0] depth;
    } frame_cfg_t;

    // slices per row for a depth code: 0 -> 1, 1 -> 2, 2/3 -> 3
    function automatic logic [1:0] slices_for_depth(input logic [1:0] depth);
        case (depth)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/scser_seq.sv
module scser_seq
    import scser_pkg::*;
#(
    parameter int NUM_ROWS = 256,
    parameter int FAST_LEN = 16,
    parameter int SLOW_LEN = 1024,
    parameter int CNT_W    = 10,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             token_in,
    input  frame_cfg_t       cfg_in,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [ROW_W-1:0] row_o,
    output logic [1:0]       nib_o,
    output logic             slow_o,
    output logic             frame_done,
    output logic             token_out
);

    seq_state_e       state;
    frame_cfg_t       cfg_q;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] row;
    logic [1:0]       nib;
    logic [1:0]       nibs;
    logic [CNT_W-1:0] last_cnt;
    logic             last_xfer;

    assign nibs      = slices_for_depth(cfg_q.depth);
    assign last_cnt  = cfg_q.slow ? CNT_W'(SLOW_LEN - 1) : CNT_W'(FAST_LEN - 1);
    assign last_xfer = (row == ROW_W'(NUM_ROWS - 1)) && (nib == nibs - 2'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            cnt   <= '0;
            row   <= '0;
            nib   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (token_in) begin
                    cfg_q <= cfg_in;
                    row   <= '0;
                    nib   <= '0;
                    state <= ST_LOAD;
                end
                ST_LOAD: begin
                    cnt   <= '0;
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (cnt == last_cnt) begin
                        if (last_xfer) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_LOAD;
                            if (nib == nibs - 2'd1) begin
                                nib <= '0;
                                row <= row + 1'b1;
                            end else begin
                                nib <= nib + 2'd1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o    = state;
    assign cnt_o      = cnt;
    assign row_o      = row;
    assign nib_o      = nib;
    assign slow_o     = cfg_q.slow;
    assign frame_done = (state == ST_DONE);
    assign token_out  = (state == ST_DONE);

    // R6: the token hand-off is a single-cycle pulse
    assert_token_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        token_out |=> !token_out);

    // R5: every load is followed directly by shifting
    assert_load_then_shift_R5: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOAD |=> state == ST_SHIFT);

    // R3: slice index stays inside the configured depth
    assert_nib_range_R3: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |-> nib < nibs);

    // R3: rows advance by at most one between loads
    assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && $past(state) == ST_SHIFT) |->
        (row == $past(row) || row == $past(row) + 1'b1));

endmodule

// File: rtl/scser_word.sv
module scser_word #(
    parameter int NUM_SC   = 32,
    parameter int SC_BITS  = 32,
    parameter int ROW_BITS = 1024,
    parameter int CNT_W    = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                shift_en,
    input  logic                slow,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [ROW_BITS-1:0] row_data,
    output logic [NUM_SC-1:0]   dout_rise,
    output logic [NUM_SC-1:0]   dout_fall,
    output logic                dout_slow
);

    localparam int SC_IDX_W = $clog2(SC_BITS);
    localparam int PAIR_W   = SC_IDX_W - 1;

    logic [ROW_BITS-1:0] word_q;
    logic [PAIR_W-1:0]   pair;
    logic                fast_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= row_data;
        end
    end

    assign pair    = cnt[PAIR_W-1:0];
    assign fast_on = shift_en && !slow;

    for (genvar s = 0; s < NUM_SC; s++) begin : g_line
        logic [SC_BITS-1:0] sc_word;
        assign sc_word      = word_q[s*SC_BITS +: SC_BITS];
        assign dout_rise[s] = fast_on && sc_word[{pair, 1'b0}];
        assign dout_fall[s] = fast_on && sc_word[{pair, 1'b1}];
    end

    assign dout_slow = shift_en && slow && word_q[cnt];

endmodule

// File: rtl/scser_top.sv
module scser_top
    import scser_pkg::*;
#(
    parameter int NUM_COLS = 256,
    parameter int SC_COLS  = 8,
    parameter int NIB_W    = 4,
    parameter int NUM_ROWS = 256,
    localparam int NUM_SC   = NUM_COLS / SC_COLS,
    localparam int ROW_BITS = NUM_COLS * NIB_W,
    localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                token_in,
    input  logic                slow_mode,
    input  logic [1:0]          count_depth,
    input  logic [ROW_BITS-1:0] row_data,
    output logic [ROW_W-1:0]    row_addr,
    output logic [1:0]          nib_sel,
    output logic [NUM_SC-1:0]   dout_rise,
    output logic [NUM_SC-1:0]   dout_fall,
    output logic                dout_slow,
    output logic                frame_done,
    output logic                token_out
);

    localparam int SC_BITS  = SC_COLS * NIB_W;
    localparam int FAST_LEN = SC_BITS / 2;
    localparam int SLOW_LEN = ROW_BITS;
    localparam int CNT_W    = $clog2(SLOW_LEN);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             slow_q;
    frame_cfg_t       cfg_in;

    assign cfg_in = '{slow: slow_mode, depth: count_depth};

    scser_seq #(
        .NUM_ROWS (NUM_ROWS),
        .FAST_LEN (FAST_LEN),
        .SLOW_LEN (SLOW_LEN),
        .CNT_W    (CNT_W),
        .ROW_W    (ROW_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .token_in   (token_in),
        .cfg_in     (cfg_in),
        .state_o    (state),
        .cnt_o      (cnt),
        .row_o      (row_addr),
        .nib_o      (nib_sel),
        .slow_o     (slow_q),
        .frame_done (frame_done),
        .token_out  (token_out)
    );

    scser_word #(
        .NUM_SC   (NUM_SC),
        .SC_BITS  (SC_BITS),
        .ROW_BITS (ROW_BITS),
        .CNT_W    (CNT_W)
    ) u_word (
        .clk       (clk),
        .rst       (rst),
        .load      (state == ST_LOAD),
        .shift_en  (state == ST_SHIFT),
        .slow      (slow_q),
        .cnt       (cnt),
        .row_data  (row_data),
        .dout_rise (dout_rise),
        .dout_fall (dout_fall),
        .dout_slow (dout_slow)
    );

    // R2: lines are silent whenever the sequencer is not shifting
    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        state != ST_SHIFT |-> (dout_rise == '0 && dout_fall == '0 && !dout_slow));

    // R7: slow line and fast lines are never active together
    assert_line_split_R7: assert property (@(posedge clk) disable iff (rst)
        dout_slow |-> (dout_rise == '0 && dout_fall == '0));

endmodule

// File: tb/scser_top_tb.sv
module scser_top_tb;

    localparam int NUM_COLS = 256;
    localparam int NUM_ROWS = 3;
    localparam int NUM_SC   = NUM_COLS / 8;
    localparam int ROW_BITS = NUM_COLS * 4;
    localparam int ROW_W    = 2;

    typedef struct {
        bit                ld;
        int                row;
        int                nib;
        logic [NUM_SC-1:0] r;
        logic [NUM_SC-1:0] f;
        logic              s;
        logic              done;
    } exp_t;

    logic                clk = 0;
    logic                rst = 1;
    logic                token_in = 0;
    logic                slow_mode = 0;
    logic [1:0]          count_depth = 0;
    logic [ROW_BITS-1:0] row_data;
    logic [ROW_W-1:0]    row_addr;
    logic [1:0]          nib_sel;
    logic [NUM_SC-1:0]   dout_rise, dout_fall;
    logic                dout_slow, frame_done, token_out;

    int checks = 0;
    int errors = 0;
    int pat = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    scser_top #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_dut (
        .clk(clk), .rst(rst), .token_in(token_in), .slow_mode(slow_mode),
        .count_depth(count_depth), .row_data(row_data), .row_addr(row_addr),
        .nib_sel(nib_sel), .dout_rise(dout_rise), .dout_fall(dout_fall),
        .dout_slow(dout_slow), .frame_done(frame_done), .token_out(token_out)
    );

    function automatic logic [ROW_BITS-1:0] pix(int r, int n, int p);
        logic [ROW_BITS-1:0] d = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            logic [3:0] v;
            if (p == 0)      v = 4'((c * 7 + r * 13 + n * 5 + 3) & 15);
            else if (p == 1) v = (c == (r * 3 + n * 11) % NUM_COLS) ? 4'hF : 4'h0;
            else             v = (c % 2 == 1) ? 4'hA : 4'h5;
            d[c*4 +: 4] = v;
        end
        return d;
    endfunction

    assign row_data = pix(int'(row_addr), int'(nib_sel), pat);

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(bit slow, int depth);
        int nn = (depth == 0) ? 1 : (depth == 1) ? 2 : 3;
        exp_t e;
        for (int r = 0; r < NUM_ROWS; r++) begin
            for (int n = 0; n < nn; n++) begin
                logic [ROW_BITS-1:0] d = pix(r, n, pat);
                e = '{ld: 1, row: r, nib: n, r: '0, f: '0, s: 0, done: 0};
                q.push_back(e);
                if (slow) begin
                    for (int j = 0; j < ROW_BITS; j++) begin
                        e = '{ld: 0, row: 0, nib: 0, r: '0, f: '0, s: d[j], done: 0};
                        q.push_back(e);
                    end
                end else begin
                    for (int k = 0; k < 16; k++) begin
                        e = '{ld: 0, row: 0, nib: 0, r: '0, f: '0, s: 0, done: 0};
                        for (int s = 0; s < NUM_SC; s++) begin
                            e.r[s] = d[s*32 + 2*k];
                            e.f[s] = d[s*32 + 2*k + 1];
                        end
                        q.push_back(e);
                    end
                end
            end
        end
        e = '{ld: 0, row: 0, nib: 0, r: '0, f: '0, s: 0, done: 1};
        q.push_back(e);
    endtask

    task automatic run_frame(bit slow, int depth, int p, bit disturb);
        int idx = 0;
        pat = p;
        @(negedge clk);
        slow_mode = slow;
        count_depth = 2'(depth);
        token_in = 1;
        build(slow, depth);
        @(negedge clk);
        token_in = 0;
        while (q.size() > 0) begin
            exp_t e = q.pop_front();
            if (disturb && idx == 5) begin
                slow_mode = ~slow;
                count_depth = 2'(3 - depth);
                token_in = 1;
            end else begin
                token_in = 0;
            end
            check("R4 R8 dout_rise", 128'(dout_rise), 128'(e.r));
            check("R4 R5 dout_fall", 128'(dout_fall), 128'(e.f));
            check("R7 dout_slow", 128'(dout_slow), 128'(e.s));
            check("R6 frame_done", 128'(frame_done), 128'(e.done));
            check("R6 token_out", 128'(token_out), 128'(e.done));
            if (e.ld) begin
                check("R3 row_addr", 128'(row_addr), 128'(e.row));
                check("R3 nib_sel", 128'(nib_sel), 128'(e.nib));
            end
            idx++;
            @(negedge clk);
        end
        token_in = 0;
        // R6: idle after the pulse
        repeat (3) begin
            check("R6 R2 idle after done", 128'({dout_rise, dout_fall, dout_slow, token_out}), 128'(0));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 reset outputs", 128'({dout_rise, dout_fall, dout_slow, frame_done, token_out}), 128'(0));
        // R2: no token, no activity
        pat = 2;
        repeat (5) begin
            @(negedge clk);
            check("R2 idle without token", 128'({dout_rise, dout_fall, dout_slow, frame_done}), 128'(0));
        end
        run_frame(0, 0, 0, 0);
        run_frame(0, 1, 1, 0);
        run_frame(0, 2, 2, 0);
        run_frame(0, 3, 0, 1);
        run_frame(1, 0, 0, 0);
        run_frame(1, 1, 1, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule